// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block collects 64 level-sensitive peripheral request lines, split into two banks of 32, plus 8 level-sensitive local request lines. Software controls it through a 32-bit register interface: one request strobe with a write flag, a byte address and write data. Read data comes back registered, one clock after the read is accepted. The block drives a normal interrupt output, `irq_o`, and a fast interrupt output, `fiq_o`.

Each peripheral bank and the local group has its own enable mask. A mask is changed through a pair of registers. Writing ones to the set register turns mask bits on. Writing ones to the clear register turns them off. A summary word gives a one-read overview: the masked local lines, one flag per peripheral bank, and direct copies of eleven chosen peripheral lines.

The fast output follows one raw source. A 7-bit index selects that source across both the peripheral and the local lines, and a separate enable bit gates it.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all enable masks, the fast-interrupt select and the fast-interrupt enable are zero. Both `irq_o` and `fiq_o` are low, whatever the input levels are.
- R2: Writing to a set register ORs the write data into its mask. Reading a set register returns the mask. The set registers are at byte offset 0x10 (bank 0, peripheral line i at bit i), 0x14 (bank 1, peripheral line 32+i at bit i) and 0x18 (local line i at bit i).
- R3: Writing to a clear register clears every mask bit where the write data is 1. The clear registers are at 0x1C (bank 0), 0x20 (bank 1) and 0x24 (local). Reading a clear register returns the bitwise inverse of the matching mask, zero-extended to 32 bits before inversion. The local clear register therefore reads ones in bits 31:8.
- R4: Writes to the local mask use only write-data bits 7:0. Higher bits are ignored.
- R5: Offset 0x04 reads the bank 0 line levels ANDed with the bank 0 mask. Offset 0x08 reads the same for bank 1.
- R6: Offset 0x00 reads the summary word:
  - bits 7:0 are the masked local lines;
  - bit 8 is set when any masked bank 0 line is high;
  - bit 9 is set when any masked bank 1 line is high;
  - bits 10 to 20 are the masked peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order;
  - bits 31:21 read zero.
- R7: Offset 0x0C holds the source select in bits 6:0 and the fast enable in bit 7. It reads back the same layout, with bits 31:8 reading zero.
- R8: A select value below 64 routes raw peripheral line (select) to the fast output. A value from 64 to 71 routes raw local line (select − 64). A value from 72 to 127 routes constant low. The enable masks play no part in this routing. `fiq_o` is low while the fast enable is 0.
- R9: `irq_o` is high when any masked peripheral line or any masked local line is high.
- R10: `irq_o` and `fiq_o` are registered. A level change shows at the output after the next clock edge. A register write shows one edge after the edge that stores the write.
- R11: A read from an unmapped or misaligned address (address bits 1:0 not zero, or offset above 0x24) returns zero. A write to such an address, or to offsets 0x00, 0x04 or 0x08, changes no state.
- R12: `bus_rdata` loads at the edge that accepts a read. It holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_lvl | input | 64 | Peripheral request levels, line i at bit i |
| local_lvl | input | 8 | Local request levels |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The bench targets these corner cases, each with the fault it would expose:

- **Local clear register read.** A design that inverted only the 8 mask bits would return zeros in the top 24 bits.
- **Fast select in the local range and past it.** A design that subtracted 64 wrongly, or wrapped indices 72 to 127 back onto real lines, would raise `fiq_o` from the wrong source.
- **Masked-off lines with the fast output.** Fast routing must use the raw level, so a design that applied the enable masks would hold `fiq_o` low.
- **Local mask high bits.** A write with only bits above 7 set must leave the local mask empty.
- **Writes to pending and unmapped offsets.** A design that decoded loosely would alter a mask through these writes.
- **Summary mirror order.** Exact bit patterns per vector catch a reversed or shifted mirror list.
- **Output timing.** Checks just before and just after the edge catch an output that is one cycle early or late.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Register slots, indexed by byte offset / 4
   localparam int IDX_BASIC_PEND = 0;
   localparam int IDX_PEND_BANK0 = 1;
   localparam int IDX_FIQ_CTL    = 3;
   localparam int IDX_EN_BANK0   = 4;
   localparam int IDX_EN_LOCAL   = 6;
   localparam int IDX_DIS_BANK0  = 7;
   localparam int IDX_DIS_LOCAL  = 9;
   localparam int NUM_REGS       = 10;

   // Summary word layout
   localparam int BANK_FLAG_LSB  = 8;
   localparam int MIRROR_LSB     = 10;
   localparam int NUM_MIRROR     = 11;

   // Peripheral line copied into summary mirror slot k
   function automatic int mirror_line(input int k);
      case (k)
         0:  return 7;
         1:  return 9;
         2:  return 10;
         3:  return 18;
         4:  return 19;
         5:  return 53;
         6:  return 54;
         7:  return 55;
         8:  return 56;
         9:  return 57;
         default: return 62;
      endcase
   endfunction

endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_we) mask_q <= mask_q | wdata;
      else if (clr_we) mask_q <= mask_q & ~wdata;
   end

   // R2: a set write only adds bits
   a_r2_set_ors : assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> (mask_q == ($past(mask_q) | $past(wdata))));

   // R3: a clear write only removes bits
   a_r3_clear_ands : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> (mask_q == ($past(mask_q) & ~$past(wdata))));

   // Mask is stable without a write
   a_r11_mask_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(mask_q));

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
   import irqc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_PERIPH = 64,
   parameter int NUM_LOCAL  = 8
) (
   input  logic [NUM_PERIPH-1:0] pend,
   input  logic [NUM_LOCAL-1:0]  local_pend,
   output logic [DATA_W-1:0]     word
);

   localparam int NB = NUM_PERIPH / DATA_W;

   logic [NUM_MIRROR-1:0] mirror;
   logic [NB-1:0]         flags;

   for (genvar k = 0; k < NUM_MIRROR; k++) begin : g_mirror
      assign mirror[k] = pend[mirror_line(k)];
   end

   for (genvar b = 0; b < NB; b++) begin : g_flag
      assign flags[b] = |pend[b*DATA_W +: DATA_W];
   end

   always_comb begin
      word                            = '0;
      word[NUM_LOCAL-1:0]             = local_pend;
      word[BANK_FLAG_LSB +: NB]       = flags;
      word[MIRROR_LSB +: NUM_MIRROR]  = mirror;
   end

endmodule

// File: rtl/irqc_fiq_route.sv
module irqc_fiq_route #(
   parameter int NUM_PERIPH = 64,
   parameter int NUM_LOCAL  = 8,
   parameter int SEL_W      = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_we,
   input  logic [SEL_W:0]        ctl_wdata,
   input  logic [NUM_PERIPH-1:0] periph_lvl,
   input  logic [NUM_LOCAL-1:0]  local_lvl,
   output logic [SEL_W:0]        ctl_q,
   output logic                  fiq_o
);

   logic [SEL_W-1:0] sel_q;
   logic             en_q;
   logic             src;
   logic             fiq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else if (ctl_we) begin
         sel_q <= ctl_wdata[SEL_W-1:0];
         en_q  <= ctl_wdata[SEL_W];
      end
   end

   // Raw source pick across both groups; indices past them give low
   always_comb begin
      src = 1'b0;
      for (int i = 0; i < NUM_PERIPH; i++)
         if (sel_q == SEL_W'(i)) src = periph_lvl[i];
      for (int i = 0; i < NUM_LOCAL; i++)
         if (sel_q == SEL_W'(NUM_PERIPH + i)) src = local_lvl[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fiq_q <= 1'b0;
      else        fiq_q <= en_q & src;
   end

   assign ctl_q = {en_q, sel_q};
   assign fiq_o = fiq_q;

   // R8: disabled fast path stays low
   a_r8_fiq_gated : assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !fiq_o);

   // R7: control holds without a write
   a_r7_ctl_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(ctl_q));

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_BANKS = 2,
   parameter int NUM_LOCAL = 8,
   parameter int SEL_W     = 7,
   parameter int ADDR_W    = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_BANKS*DATA_W-1:0]   periph_lvl,
   input  logic [NUM_LOCAL-1:0]          local_lvl,
   input  logic                          bus_valid,
   input  logic                          bus_write,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             bus_wdata,
   output logic [DATA_W-1:0]             bus_rdata,
   output logic                          irq_o,
   output logic                          fiq_o
);

   localparam int NUM_PERIPH = NUM_BANKS * DATA_W;
   localparam int REG_W      = ADDR_W - 2;

   // Elaboration-time parameter checks
   if (NUM_BANKS != 2) begin : g_bad_banks
      $error("register map holds exactly two peripheral banks");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("summary layout needs a 32-bit data path");
   end
   if (NUM_LOCAL < 1 || NUM_LOCAL > 8) begin : g_bad_local
      $error("local group must be 1 to 8 lines");
   end
   if ((1 << SEL_W) < NUM_PERIPH + NUM_LOCAL) begin : g_bad_sel
      $error("select width too small for all sources");
   end
   if (SEL_W + 1 > DATA_W || ADDR_W < 6) begin : g_bad_misc
      $error("select or address width out of range");
   end

   // Address decode
   logic [REG_W-1:0]    reg_idx;
   logic                mapped;
   logic [NUM_REGS-1:0] hit;
   logic                wr_req;
   logic                rd_req;

   assign reg_idx = bus_addr[ADDR_W-1:2];
   assign mapped  = (bus_addr[1:0] == 2'b00) && (reg_idx < REG_W'(NUM_REGS));
   assign wr_req  = bus_valid & bus_write;
   assign rd_req  = bus_valid & ~bus_write;

   always_comb begin
      for (int k = 0; k < NUM_REGS; k++)
         hit[k] = mapped && (reg_idx == REG_W'(k));
   end

   // Peripheral masks, one per bank
   logic [NUM_PERIPH-1:0] periph_mask;
   logic [NUM_PERIPH-1:0] pend;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irqc_mask_bank #(.W(DATA_W)) u_mask (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (wr_req & hit[IDX_EN_BANK0 + b]),
         .clr_we (wr_req & hit[IDX_DIS_BANK0 + b]),
         .wdata  (bus_wdata),
         .mask_q (periph_mask[b*DATA_W +: DATA_W])
      );
   end

   assign pend = periph_lvl & periph_mask;

   // Local mask
   logic [NUM_LOCAL-1:0] local_mask;
   logic [NUM_LOCAL-1:0] local_pend;
   logic [DATA_W-1:0]    local_mask_ext;

   irqc_mask_bank #(.W(NUM_LOCAL)) u_local_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_req & hit[IDX_EN_LOCAL]),
      .clr_we (wr_req & hit[IDX_DIS_LOCAL]),
      .wdata  (bus_wdata[NUM_LOCAL-1:0]),
      .mask_q (local_mask)
   );

   assign local_pend = local_lvl & local_mask;

   always_comb begin
      local_mask_ext                = '0;
      local_mask_ext[NUM_LOCAL-1:0] = local_mask;
   end

   // Summary word
   logic [DATA_W-1:0] basic_word;

   irqc_summary #(
      .DATA_W     (DATA_W),
      .NUM_PERIPH (NUM_PERIPH),
      .NUM_LOCAL  (NUM_LOCAL)
   ) u_summary (
      .pend       (pend),
      .local_pend (local_pend),
      .word       (basic_word)
   );

   // Fast interrupt routing
   logic [SEL_W:0] fiq_ctl;

   irqc_fiq_route #(
      .NUM_PERIPH (NUM_PERIPH),
      .NUM_LOCAL  (NUM_LOCAL),
      .SEL_W      (SEL_W)
   ) u_fiq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_we     (wr_req & hit[IDX_FIQ_CTL]),
      .ctl_wdata  (bus_wdata[SEL_W:0]),
      .periph_lvl (periph_lvl),
      .local_lvl  (local_lvl),
      .ctl_q      (fiq_ctl),
      .fiq_o      (fiq_o)
   );

   // Read mux
   logic [DATA_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (hit[IDX_BASIC_PEND]) rd_word = basic_word;
      if (hit[IDX_FIQ_CTL])    rd_word[SEL_W:0] = fiq_ctl;
      if (hit[IDX_EN_LOCAL])   rd_word = local_mask_ext;
      if (hit[IDX_DIS_LOCAL])  rd_word = ~local_mask_ext;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit[IDX_PEND_BANK0 + b]) rd_word = pend[b*DATA_W +: DATA_W];
         if (hit[IDX_EN_BANK0 + b])   rd_word = periph_mask[b*DATA_W +: DATA_W];
         if (hit[IDX_DIS_BANK0 + b])  rd_word = ~periph_mask[b*DATA_W +: DATA_W];
      end
   end

   // Registered read data and normal interrupt
   logic [DATA_W-1:0] rdata_q;
   logic              irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         if (rd_req) rdata_q <= rd_word;
         irq_q <= (|pend) | (|local_pend);
      end
   end

   assign bus_rdata = rdata_q;
   assign irq_o     = irq_q;

   // R9/R10: output follows masked sources one edge later
   a_r9_irq_rises : assert property (@(posedge clk) disable iff (!rst_n)
      ((|pend) || (|local_pend)) |=> irq_o);
   a_r9_irq_falls : assert property (@(posedge clk) disable iff (!rst_n)
      !((|pend) || (|local_pend)) |=> !irq_o);

   // R11: unmapped read returns zero
   a_r11_unmapped_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !mapped) |=> (bus_rdata == '0));

   // R12: read data holds without a read
   a_r12_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(bus_rdata));

endmodule

// File: tb/banked_irq_ctrl_test.sv
`timescale 1ns/1ps
module banked_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] periph_lvl = '0;
   logic [7:0]  local_lvl = '0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic        fiq_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   banked_irq_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .periph_lvl (periph_lvl),
      .local_lvl  (local_lvl),
      .bus_valid  (bus_valid),
      .bus_write  (bus_write),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_o      (irq_o),
      .fiq_o      (fiq_o)
   );

   localparam int MIR [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

   // Each vector: {periph levels, local levels, bank0 mask, bank1 mask, local mask}
   localparam logic [143:0] VECS [6] = '{
      {64'h0, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF},
      {64'h4000_0000_0000_0000, 8'h00, 32'h0, 32'h4000_0000, 8'h00},
      {64'h0000_0000_000C_0680, 8'h00, 32'h000C_0280, 32'h0, 8'h00},
      {64'h0, 8'hA5, 32'h0, 32'h0, 8'h0F},
      {64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 32'h0, 32'h0, 8'h00},
      {64'h03E0_0000_0000_0001, 8'h00, 32'h1, 32'h0280_0000, 8'h00}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(posedge clk); @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic clear_all();
      bus_wr(8'h1C, 32'hFFFF_FFFF);
      bus_wr(8'h20, 32'hFFFF_FFFF);
      bus_wr(8'h24, 32'hFFFF_FFFF);
   endtask

   function automatic logic [31:0] exp_basic(input logic [63:0] lv, input logic [7:0] ll,
                                             input logic [63:0] m, input logic [7:0] ml);
      logic [63:0] p;
      logic [31:0] r;
      p = lv & m;
      r = {24'h0, ll & ml};
      r[8] = |p[31:0];
      r[9] = |p[63:32];
      for (int i = 0; i < 11; i++) r[10+i] = p[MIR[i]];
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic [63:0] lv, m;
      logic [7:0]  ll, ml;

      // R1: reset state, levels high while masks are clear
      periph_lvl = '1;
      local_lvl  = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      chk("R1 irq after reset", 32'(irq_o), 32'h0);
      chk("R1 fiq after reset", 32'(fiq_o), 32'h0);
      bus_rd(8'h0C, rd); chk("R1 fiq ctl", rd, 32'h0);
      bus_rd(8'h10, rd); chk("R1 bank0 mask", rd, 32'h0);
      bus_rd(8'h14, rd); chk("R1 bank1 mask", rd, 32'h0);
      bus_rd(8'h18, rd); chk("R1 local mask", rd, 32'h0);
      bus_rd(8'h24, rd); chk("R3 local clear read upper ones", rd, 32'hFFFF_FFFF);

      // Vector table: R2 R3 R5 R6 R9
      foreach (VECS[v]) begin
         {lv, ll, m[31:0], m[63:32], ml} = VECS[v];
         clear_all();
         periph_lvl = lv;
         local_lvl  = ll;
         bus_wr(8'h10, m[31:0]);
         bus_wr(8'h14, m[63:32]);
         bus_wr(8'h18, {24'h0, ml});
         tick();
         chk($sformatf("R9 irq vec%0d", v), 32'(irq_o),
             32'(((lv & m) != 0) || ((ll & ml) != 0)));
         bus_rd(8'h00, rd); chk($sformatf("R6 summary vec%0d", v), rd, exp_basic(lv, ll, m, ml));
         bus_rd(8'h04, rd); chk($sformatf("R5 pend0 vec%0d", v), rd, lv[31:0] & m[31:0]);
         bus_rd(8'h08, rd); chk($sformatf("R5 pend1 vec%0d", v), rd, lv[63:32] & m[63:32]);
         bus_rd(8'h10, rd); chk($sformatf("R2 en0 vec%0d", v), rd, m[31:0]);
         bus_rd(8'h14, rd); chk($sformatf("R2 en1 vec%0d", v), rd, m[63:32]);
         bus_rd(8'h18, rd); chk($sformatf("R2 enl vec%0d", v), rd, {24'h0, ml});
         bus_rd(8'h1C, rd); chk($sformatf("R3 dis0 vec%0d", v), rd, ~m[31:0]);
         bus_rd(8'h20, rd); chk($sformatf("R3 dis1 vec%0d", v), rd, ~m[63:32]);
         bus_rd(8'h24, rd); chk($sformatf("R3 disl vec%0d", v), rd, ~{24'h0, ml});
      end

      // R2: set writes accumulate
      periph_lvl = '0; local_lvl = '0;
      clear_all();
      bus_wr(8'h10, 32'h0000_0001);
      bus_wr(8'h10, 32'h0000_0100);
      bus_rd(8'h10, rd); chk("R2 accumulate", rd, 32'h0000_0101);

      // R3: clear drops only the ones written
      bus_wr(8'h1C, 32'h0000_0001);
      bus_rd(8'h10, rd); chk("R3 clear one bit", rd, 32'h0000_0100);
      bus_rd(8'h1C, rd); chk("R3 clear read inverse", rd, 32'hFFFF_FEFF);

      // R4: local mask ignores bits above 7
      bus_wr(8'h18, 32'hFFFF_FF00);
      bus_rd(8'h18, rd); chk("R4 high bits ignored", rd, 32'h0);
      bus_wr(8'h18, 32'h0000_013C);
      bus_rd(8'h18, rd); chk("R4 low byte kept", rd, 32'h0000_003C);

      // R11: writes to pending and unmapped offsets change nothing
      bus_wr(8'h00, 32'hFFFF_FFFF);
      bus_wr(8'h04, 32'hFFFF_FFFF);
      bus_wr(8'h08, 32'hFFFF_FFFF);
      bus_wr(8'h28, 32'hFFFF_FFFF);
      bus_wr(8'h11, 32'hFFFF_FFFF);
      bus_wr(8'h3C, 32'hFFFF_FFFF);
      bus_rd(8'h10, rd); chk("R11 bank0 mask untouched", rd, 32'h0000_0100);
      bus_rd(8'h14, rd); chk("R11 bank1 mask untouched", rd, 32'h0);
      bus_rd(8'h18, rd); chk("R11 local mask untouched", rd, 32'h0000_003C);
      bus_rd(8'h0C, rd); chk("R11 fiq ctl untouched", rd, 32'h0);
      bus_rd(8'h28, rd); chk("R11 unmapped read", rd, 32'h0);
      bus_rd(8'h0D, rd); chk("R11 misaligned read", rd, 32'h0);

      // R12: read data holds through idle cycles and writes
      bus_rd(8'h18, rd);
      tick(); tick();
      bus_wr(8'h10, 32'h0000_0002);
      chk("R12 rdata held", bus_rdata, 32'h0000_003C);

      // R7 / R8: fast routing uses raw levels
      clear_all();
      periph_lvl = 64'h1 << 40;
      bus_wr(8'h0C, 32'hFFFF_FFA8);
      bus_rd(8'h0C, rd); chk("R7 ctl readback", rd, 32'h0000_00A8);
      chk("R8 fiq raw peripheral 40", 32'(fiq_o), 32'h1);
      chk("R9 irq low with masks clear", 32'(irq_o), 32'h0);
      bus_wr(8'h0C, 32'h0000_00C3);
      periph_lvl = '0;
      local_lvl  = 8'h08;
      tick();
      chk("R8 fiq local 3", 32'(fiq_o), 32'h1);
      local_lvl = 8'h00;
      tick();
      chk("R8 fiq local 3 low", 32'(fiq_o), 32'h0);
      bus_wr(8'h0C, 32'h0000_00CA);
      local_lvl  = 8'hFF;
      periph_lvl = '1;
      tick();
      chk("R8 select past sources", 32'(fiq_o), 32'h0);
      bus_wr(8'h0C, 32'h0000_0028);
      tick();
      chk("R8 fiq disabled", 32'(fiq_o), 32'h0);

      // R10: output timing
      periph_lvl = '0; local_lvl = '0;
      bus_wr(8'h10, 32'h0000_0008);
      tick();
      chk("R10 irq idle", 32'(irq_o), 32'h0);
      periph_lvl[3] = 1'b1;
      #1;
      chk("R10 irq before edge", 32'(irq_o), 32'h0);
      @(negedge clk);
      chk("R10 irq after edge", 32'(irq_o), 32'h1);
      bus_wr(8'h1C, 32'h0000_0008);
      chk("R10 irq at mask edge", 32'(irq_o), 32'h1);
      tick();
      chk("R10 irq one edge later", 32'(irq_o), 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule